// File: doc/BRIEF.md
# Upstream Address Limit Filter

This block sits in the upstream request path of a root port. Every request header that arrives from a downstream device is classified by its kind and by its 64-bit address. A memory request whose address reaches or goes beyond 2^43 lies outside the window the host can reach. A memory request of that kind is never forwarded.

The block treats reads and writes differently when the address is out of range. An out-of-range read is answered on a separate completion port with an Unsupported Request status. The completion echoes the requester ID and tag of the read and carries no data. An out-of-range write is discarded without any response. The block counts each discarded write in a saturating counter and signals it with a one-cycle event pulse.

Memory requests with legal addresses leave on the output side unchanged, one cycle after they are accepted. Configuration and message requests leave the same way and are never checked. Both sides use valid/ready handshakes.

The control is a two-state machine:
- `ST_FLOW`: the normal state. The input is ready whenever the output register is free.
- `ST_UR_HOLD`: a rejected read is waiting on the completion port. The input is held off in this state.

The transitions are:
- `T_REJECT_RD` (`ST_FLOW` to `ST_UR_HOLD`): an out-of-range read is accepted.
- `T_CPL_TAKEN` (`ST_UR_HOLD` to `ST_FLOW`): the completion is taken.

Top module: `up_addr_guard`

## Requirements
- R1: After reset the block shows the following values: out_valid, cpl_valid and wr_drop_pulse are 0, wr_drop_count is 0 and in_ready is 1.
- R2: Request kinds are encoded as 0 = memory read, 1 = memory write, 2 = configuration and 3 = message. A memory request whose address bits 63:43 are all zero appears on the output with identical kind, address, requester ID and tag. It appears exactly one clock edge after it is accepted.
- R3: With out_ready held high, a new request is accepted on every clock edge. Each accepted request is presented on the following cycle, in order.
- R4: A memory read with any of address bits 63:43 set is not forwarded. It produces cpl_valid on the next cycle with its requester ID and tag and cpl_status = 3'b001 (Unsupported Request).
- R5: A memory write with any of address bits 63:43 set is not forwarded and produces no completion.
- R6: Each discarded write raises wr_drop_pulse for exactly one cycle and adds one to wr_drop_count on the same edge.
- R7: wr_drop_count stops at 16'hFFFF and stays there under further discarded writes.
- R8: While a rejected read's completion is pending, in_ready is 0 and the completion fields are held stable. After the edge on which cpl_ready is high, the completion is withdrawn and in_ready returns.
- R9: Configuration and message requests are forwarded unchanged even when address bits 63:43 are set. They never produce a completion or a drop.
- R10: While out_valid is high and out_ready is low, the output fields are held stable and in_ready is 0.
- R11: A forwarded memory request never has a nonzero bit in address bits 63:43. The highest legal address, 2^43-1, is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming request header valid |
| in_ready | output | 1 | Block can accept a header |
| in_kind | input | 2 | Request kind (0 read, 1 write, 2 config, 3 message) |
| in_addr | input | 64 | Request address |
| in_rid | input | 16 | Requester ID |
| in_tag | input | 8 | Request tag |
| out_valid | output | 1 | Forwarded header valid |
| out_ready | input | 1 | Downstream consumer takes header |
| out_kind | output | 2 | Forwarded kind |
| out_addr | output | 64 | Forwarded address |
| out_rid | output | 16 | Forwarded requester ID |
| out_tag | output | 8 | Forwarded tag |
| cpl_valid | output | 1 | Rejection completion valid |
| cpl_ready | input | 1 | Completion generator takes completion |
| cpl_rid | output | 16 | Requester ID of rejected read |
| cpl_tag | output | 8 | Tag of rejected read |
| cpl_status | output | 3 | Completion status, 3'b001 for Unsupported Request |
| wr_drop_pulse | output | 1 | One-cycle pulse per discarded write |
| wr_drop_count | output | 16 | Saturating count of discarded writes |

## Verification
Two situations are hard to reach from the ports.

The first is a rejected read that stalls the input while another legal request is already being offered. The stimulus holds cpl_ready low and keeps a legal header on the input through the stall. It then checks three things: the held header is not taken, the completion is released on the edge where cpl_ready rises, and the held header is accepted only on the edge after that.

The second is counter saturation, which needs 65,535 discarded writes. The stimulus keeps one out-of-range write asserted on the input for more than that many cycles and then checks that the count sits at its ceiling while the pulse keeps firing.

// File: rtl/uaf_pkg.sv
package uaf_pkg;

    typedef enum logic [1:0] {
        KIND_MRD = 2'd0,
        KIND_MWR = 2'd1,
        KIND_CFG = 2'd2,
        KIND_MSG = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        CST_SC = 3'd0,
        CST_UR = 3'd1
    } cpl_status_e;

    typedef enum logic {
        ST_FLOW    = 1'b0,
        ST_UR_HOLD = 1'b1
    } guard_state_e;

endpackage

// File: rtl/uaf_classify.sv
module uaf_classify
    import uaf_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int LIMIT_BIT = 43
) (
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    output logic              over_limit,
    output logic              reject_rd,
    output logic              reject_wr,
    output logic              pass_thru
);

    logic is_rd;
    logic is_wr;

    generate
        if (LIMIT_BIT >= ADDR_W) begin : g_no_window
            assign over_limit = 1'b0;
        end else begin : g_window
            localparam int HI_W = ADDR_W - LIMIT_BIT;
            logic [HI_W-1:0] hi_bits;
            assign hi_bits    = addr[ADDR_W-1:LIMIT_BIT];
            assign over_limit = |hi_bits;
        end
    endgenerate

    always_comb begin
        is_rd     = (kind == KIND_MRD);
        is_wr     = (kind == KIND_MWR);
        reject_rd = is_rd && over_limit;
        reject_wr = is_wr && over_limit;
        pass_thru = !(reject_rd || reject_wr);
    end

endmodule

// File: rtl/uaf_fwd_stage.sv
module uaf_fwd_stage #(
    parameter int ADDR_W = 64,
    parameter int RID_W  = 16,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [1:0]        kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [RID_W-1:0]  rid_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              out_ready,
    output logic              free,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [ADDR_W-1:0] out_addr,
    output logic [RID_W-1:0]  out_rid,
    output logic [TAG_W-1:0]  out_tag
);

    assign free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_kind <= '0;
            out_addr <= '0;
            out_rid  <= '0;
            out_tag  <= '0;
        end else if (load) begin
            out_kind <= kind_i;
            out_addr <= addr_i;
            out_rid  <= rid_i;
            out_tag  <= tag_i;
        end
    end

endmodule

// File: rtl/uaf_drop_counter.sv
module uaf_drop_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    output logic             pulse,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            count <= '0;
        end else begin
            pulse <= hit;
            if (hit && (count != CNT_MAX)) begin
                count <= count + CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/up_addr_guard.sv
module up_addr_guard
    import uaf_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int LIMIT_BIT = 43,
    parameter int RID_W     = 16,
    parameter int TAG_W     = 8,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_kind,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [RID_W-1:0]  in_rid,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_kind,
    output logic [ADDR_W-1:0] out_addr,
    output logic [RID_W-1:0]  out_rid,
    output logic [TAG_W-1:0]  out_tag,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [RID_W-1:0]  cpl_rid,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [2:0]        cpl_status,
    output logic              wr_drop_pulse,
    output logic [CNT_W-1:0]  wr_drop_count
);

    guard_state_e state_q;
    guard_state_e state_d;

    logic over_limit;
    logic reject_rd;
    logic reject_wr;
    logic pass_thru;
    logic fwd_free;
    logic accept;
    logic fwd_load;
    logic take_reject_rd;
    logic take_reject_wr;

    logic [RID_W-1:0] hold_rid_q;
    logic [TAG_W-1:0] hold_tag_q;

    uaf_classify #(
        .ADDR_W   (ADDR_W),
        .LIMIT_BIT(LIMIT_BIT)
    ) u_classify (
        .kind      (in_kind),
        .addr      (in_addr),
        .over_limit(over_limit),
        .reject_rd (reject_rd),
        .reject_wr (reject_wr),
        .pass_thru (pass_thru)
    );

    uaf_fwd_stage #(
        .ADDR_W(ADDR_W),
        .RID_W (RID_W),
        .TAG_W (TAG_W)
    ) u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fwd_load),
        .kind_i   (in_kind),
        .addr_i   (in_addr),
        .rid_i    (in_rid),
        .tag_i    (in_tag),
        .out_ready(out_ready),
        .free     (fwd_free),
        .out_valid(out_valid),
        .out_kind (out_kind),
        .out_addr (out_addr),
        .out_rid  (out_rid),
        .out_tag  (out_tag)
    );

    uaf_drop_counter #(
        .CNT_W(CNT_W)
    ) u_drops (
        .clk  (clk),
        .rst_n(rst_n),
        .hit  (take_reject_wr),
        .pulse(wr_drop_pulse),
        .count(wr_drop_count)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        in_ready   = 1'b0;
        cpl_valid  = 1'b0;
        cpl_status = CST_SC;
        unique case (state_q)
            ST_FLOW: begin
                in_ready = fwd_free;
                if (in_valid && fwd_free && reject_rd) begin
                    state_d = ST_UR_HOLD;          // T_REJECT_RD
                end
            end
            ST_UR_HOLD: begin
                cpl_valid  = 1'b1;
                cpl_status = CST_UR;
                if (cpl_ready) begin
                    state_d = ST_FLOW;             // T_CPL_TAKEN
                end
            end
            default: begin
                state_d = ST_FLOW;
            end
        endcase
    end

    assign accept         = in_valid && in_ready;
    assign fwd_load       = accept && pass_thru;
    assign take_reject_rd = accept && reject_rd;
    assign take_reject_wr = accept && reject_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_rid_q <= '0;
            hold_tag_q <= '0;
        end else if (take_reject_rd) begin
            hold_rid_q <= in_rid;
            hold_tag_q <= in_tag;
        end
    end

    assign cpl_rid = hold_rid_q;
    assign cpl_tag = hold_tag_q;

endmodule

// File: rtl/uaf_checker.sv
module uaf_checker #(
    parameter int ADDR_W    = 64,
    parameter int LIMIT_BIT = 43,
    parameter int RID_W     = 16,
    parameter int TAG_W     = 8,
    parameter int CNT_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [1:0]        in_kind,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [1:0]        out_kind,
    input logic [ADDR_W-1:0] out_addr,
    input logic [TAG_W-1:0]  out_tag,
    input logic              cpl_valid,
    input logic              cpl_ready,
    input logic [RID_W-1:0]  cpl_rid,
    input logic [TAG_W-1:0]  cpl_tag,
    input logic [2:0]        cpl_status,
    input logic              wr_drop_pulse,
    input logic [CNT_W-1:0]  wr_drop_count
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic in_high;
    logic out_high;
    assign in_high  = (in_addr  >> LIMIT_BIT) != '0;
    assign out_high = (out_addr >> LIMIT_BIT) != '0;

    assert_fwd_below_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind[1] == 1'b0) |-> !out_high);

    assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_tag)));

    assert_out_full_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_cpl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_rid) && $stable(cpl_tag)));

    assert_cpl_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> !in_ready);

    assert_rd_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_kind == 2'd0 && in_high) |=> (cpl_valid && !out_valid));

    assert_cpl_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (cpl_status == 3'b001));

    assert_wr_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_kind == 2'd1 && in_high) |=> (wr_drop_pulse && !cpl_valid));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop_pulse |-> ((wr_drop_count == $past(wr_drop_count) + ONE) || (&wr_drop_count)));

    assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_drop_pulse |-> $stable(wr_drop_count));

endmodule

bind up_addr_guard uaf_checker #(
    .ADDR_W   (ADDR_W),
    .LIMIT_BIT(LIMIT_BIT),
    .RID_W    (RID_W),
    .TAG_W    (TAG_W),
    .CNT_W    (CNT_W)
) u_uaf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_kind      (in_kind),
    .in_addr      (in_addr),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_kind     (out_kind),
    .out_addr     (out_addr),
    .out_tag      (out_tag),
    .cpl_valid    (cpl_valid),
    .cpl_ready    (cpl_ready),
    .cpl_rid      (cpl_rid),
    .cpl_tag      (cpl_tag),
    .cpl_status   (cpl_status),
    .wr_drop_pulse(wr_drop_pulse),
    .wr_drop_count(wr_drop_count)
);

// File: tb/test_up_addr_guard.sv
module test_up_addr_guard;

    localparam logic [1:0] K_RD  = 2'd0;
    localparam logic [1:0] K_WR  = 2'd1;
    localparam logic [1:0] K_CFG = 2'd2;
    localparam logic [1:0] K_MSG = 2'd3;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [1:0]  in_kind;
    logic [63:0] in_addr;
    logic [15:0] in_rid;
    logic [7:0]  in_tag;
    logic        out_valid;
    logic        out_ready;
    logic [1:0]  out_kind;
    logic [63:0] out_addr;
    logic [15:0] out_rid;
    logic [7:0]  out_tag;
    logic        cpl_valid;
    logic        cpl_ready;
    logic [15:0] cpl_rid;
    logic [7:0]  cpl_tag;
    logic [2:0]  cpl_status;
    logic        wr_drop_pulse;
    logic [15:0] wr_drop_count;

    int checks = 0;
    int errors = 0;
    int exp_drops = 0;
    bit done = 0;

    up_addr_guard i_up_addr_guard (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
        .in_addr(in_addr), .in_rid(in_rid), .in_tag(in_tag),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_addr(out_addr), .out_rid(out_rid), .out_tag(out_tag),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_rid(cpl_rid),
        .cpl_tag(cpl_tag), .cpl_status(cpl_status),
        .wr_drop_pulse(wr_drop_pulse), .wr_drop_count(wr_drop_count)
    );

    initial begin
        clk = 1'b0;
        forever #5 clk = ~clk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic drive(input logic [1:0] k, input logic [63:0] a,
                         input logic [15:0] r, input logic [7:0] t);
        in_valid = 1'b1;
        in_kind  = k;
        in_addr  = a;
        in_rid   = r;
        in_tag   = t;
    endtask

    task automatic idle();
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [1:0] k,
                              input logic [63:0] a, input logic [15:0] r,
                              input logic [7:0] t);
        chk(out_valid === 1'b1, req, "out_valid", 64'(out_valid), 64'd1);
        chk(out_kind === k, req, "out_kind", 64'(out_kind), 64'(k));
        chk(out_addr === a, req, "out_addr", out_addr, a);
        chk(out_rid === r && out_tag === t, req, "out_rid/tag",
            {40'd0, out_rid, out_tag}, {40'd0, r, t});
    endtask

    task automatic test_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_kind = '0; in_addr = '0;
        in_rid = '0; in_tag = '0; out_ready = 1'b1; cpl_ready = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        exp_drops = 0;
        // R1
        chk(out_valid === 1'b0, "R1", "out_valid", 64'(out_valid), 64'd0);
        chk(cpl_valid === 1'b0, "R1", "cpl_valid", 64'(cpl_valid), 64'd0);
        chk(wr_drop_pulse === 1'b0, "R1", "wr_drop_pulse", 64'(wr_drop_pulse), 64'd0);
        chk(wr_drop_count === 16'd0, "R1", "wr_drop_count", 64'(wr_drop_count), 64'd0);
        chk(in_ready === 1'b1, "R1", "in_ready", 64'(in_ready), 64'd1);
    endtask

    task automatic test_pass_legal();
        drive(K_RD, 64'h0000_0123_4567_89A0, 16'h0A01, 8'h11);
        tick();
        idle();
        expect_out("R2", K_RD, 64'h0000_0123_4567_89A0, 16'h0A01, 8'h11);
        drive(K_WR, 64'h0000_0000_FFFF_0000, 16'h0B02, 8'h22);
        tick();
        idle();
        expect_out("R2", K_WR, 64'h0000_0000_FFFF_0000, 16'h0B02, 8'h22);
        tick();
        chk(out_valid === 1'b0, "R2", "out_valid after drain", 64'(out_valid), 64'd0);
    endtask

    task automatic test_throughput();
        for (int i = 0; i < 8; i++) begin
            chk(in_ready === 1'b1, "R3", "in_ready each cycle", 64'(in_ready), 64'd1);
            drive((i % 2 == 0) ? K_RD : K_WR, 64'(i) << 12, 16'(16'h100 + i), 8'(i));
            tick();
            expect_out("R3", (i % 2 == 0) ? K_RD : K_WR, 64'(i) << 12,
                       16'(16'h100 + i), 8'(i));
        end
        idle();
        tick();
        chk(out_valid === 1'b0, "R3", "out_valid after burst", 64'(out_valid), 64'd0);
    endtask

    task automatic test_read_reject();
        cpl_ready = 1'b0;
        drive(K_RD, 64'h0000_0800_0000_0000, 16'hBEEF, 8'h5A);  // bit 43 set
        tick();
        chk(cpl_valid === 1'b1, "R4", "cpl_valid", 64'(cpl_valid), 64'd1);
        chk(cpl_rid === 16'hBEEF, "R4", "cpl_rid", 64'(cpl_rid), 64'hBEEF);
        chk(cpl_tag === 8'h5A, "R4", "cpl_tag", 64'(cpl_tag), 64'h5A);
        chk(cpl_status === 3'b001, "R4", "cpl_status", 64'(cpl_status), 64'd1);
        chk(out_valid === 1'b0, "R4", "not forwarded", 64'(out_valid), 64'd0);
        chk(in_ready === 1'b0, "R8", "in_ready during hold", 64'(in_ready), 64'd0);
        // offer a legal request while stalled
        drive(K_WR, 64'h0000_0000_0000_4000, 16'h0C03, 8'h33);
        tick();
        tick();
        chk(out_valid === 1'b0, "R8", "stalled request not taken", 64'(out_valid), 64'd0);
        chk(cpl_valid === 1'b1 && cpl_tag === 8'h5A, "R8", "completion held",
            64'(cpl_tag), 64'h5A);
        cpl_ready = 1'b1;
        tick();
        cpl_ready = 1'b0;
        chk(cpl_valid === 1'b0, "R8", "completion withdrawn", 64'(cpl_valid), 64'd0);
        chk(in_ready === 1'b1, "R8", "in_ready back", 64'(in_ready), 64'd1);
        chk(out_valid === 1'b0, "R8", "held request not yet taken", 64'(out_valid), 64'd0);
        tick();
        idle();
        expect_out("R8", K_WR, 64'h0000_0000_0000_4000, 16'h0C03, 8'h33);
        tick();
    endtask

    task automatic test_write_drop();
        drive(K_WR, 64'h8000_0000_0000_0000, 16'h0D04, 8'h44);  // bit 63 set
        tick();
        idle();
        exp_drops++;
        chk(out_valid === 1'b0, "R5", "write not forwarded", 64'(out_valid), 64'd0);
        chk(cpl_valid === 1'b0, "R5", "no completion", 64'(cpl_valid), 64'd0);
        chk(wr_drop_pulse === 1'b1, "R6", "pulse high", 64'(wr_drop_pulse), 64'd1);
        chk(wr_drop_count === 16'(exp_drops), "R6", "count step",
            64'(wr_drop_count), 64'(exp_drops));
        tick();
        chk(wr_drop_pulse === 1'b0, "R6", "pulse one cycle", 64'(wr_drop_pulse), 64'd0);
        chk(wr_drop_count === 16'(exp_drops), "R6", "count stays",
            64'(wr_drop_count), 64'(exp_drops));
    endtask

    task automatic test_bypass();
        drive(K_CFG, 64'hFFFF_0000_0000_0010, 16'h0E05, 8'h55);
        tick();
        expect_out("R9", K_CFG, 64'hFFFF_0000_0000_0010, 16'h0E05, 8'h55);
        drive(K_MSG, 64'h0001_0000_0000_0000, 16'h0F06, 8'h66);
        tick();
        idle();
        expect_out("R9", K_MSG, 64'h0001_0000_0000_0000, 16'h0F06, 8'h66);
        chk(cpl_valid === 1'b0 && wr_drop_pulse === 1'b0, "R9", "no cpl/drop",
            64'({cpl_valid, wr_drop_pulse}), 64'd0);
        chk(wr_drop_count === 16'(exp_drops), "R9", "count unchanged",
            64'(wr_drop_count), 64'(exp_drops));
        tick();
    endtask

    task automatic test_backpressure();
        out_ready = 1'b0;
        drive(K_RD, 64'h0000_0000_0000_A000, 16'h1111, 8'h77);
        tick();
        expect_out("R10", K_RD, 64'h0000_0000_0000_A000, 16'h1111, 8'h77);
        chk(in_ready === 1'b0, "R10", "in_ready low when full", 64'(in_ready), 64'd0);
        drive(K_WR, 64'h0000_0000_0000_B000, 16'h2222, 8'h88);
        tick();
        tick();
        expect_out("R10", K_RD, 64'h0000_0000_0000_A000, 16'h1111, 8'h77);
        out_ready = 1'b1;
        tick();
        idle();
        expect_out("R10", K_WR, 64'h0000_0000_0000_B000, 16'h2222, 8'h88);
        tick();
        chk(out_valid === 1'b0, "R10", "drained", 64'(out_valid), 64'd0);
    endtask

    task automatic test_boundary();
        drive(K_RD, 64'h0000_07FF_FFFF_FFFF, 16'h3333, 8'h99);
        tick();
        idle();
        expect_out("R11", K_RD, 64'h0000_07FF_FFFF_FFFF, 16'h3333, 8'h99);
        chk(cpl_valid === 1'b0, "R11", "no completion at top legal",
            64'(cpl_valid), 64'd0);
        tick();
    endtask

    task automatic test_saturate();
        drive(K_WR, 64'h0000_1000_0000_0000, 16'h4444, 8'hAA);
        repeat (65600) tick();
        chk(wr_drop_count === 16'hFFFF, "R7", "count saturated",
            64'(wr_drop_count), 64'hFFFF);
        chk(wr_drop_pulse === 1'b1, "R7", "pulse still fires", 64'(wr_drop_pulse), 64'd1);
        tick();
        idle();
        chk(wr_drop_count === 16'hFFFF, "R7", "count holds at max",
            64'(wr_drop_count), 64'hFFFF);
        tick();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_pass_legal();
        test_throughput();
        test_read_reject();
        test_write_drop();
        test_bypass();
        test_backpressure();
        test_boundary();
        test_saturate();
        test_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule